// File: doc/BRIEF.md
# Interrupt status, enable and mask register unit

This block holds the interrupt state of a peripheral. Single-cycle event pulses, or held level conditions, from the datapath latch into a status register. Software acknowledges an event by writing ones to the status address. Enabling is done through a write-only set port and disabling through a separate write-only clear port. A read-only view of the resulting mask lets software see which sources are enabled. All four addresses use one 7-bit layout, and only that layout is implemented.

The unit drives a single interrupt line. This line is asserted when any status bit whose mask bit is also set is active. The line comes from a register. Access is through a plain register bus with an address, a write strobe, write data and registered read data.

Top module: `irq_regs_unit`

## Requirements
- R1: After synchronous reset the status register, the mask register, the interrupt line and the read data are all zero.
- R2: Offsets: status reads at 0x04 and the mask view reads at 0x10. Reading the set port (0x08), the clear port (0x0C) or any other address returns zero. Read data appears on the clock edge after the address is presented.
- R3: A one on event input bit i sets status bit i. The layout is bit 1 mode fault, bit 2 TX below watermark, bit 3 TX full and bit 4 RX not empty; bits 0, 5 and 6 are general sources. Status holds its bits until they are cleared.
- R4: Writing to 0x04 clears exactly the status bits written as one. Bits written as zero are unchanged.
- R5: When an event and a clear of the same bit happen in the same cycle, the event wins and the bit stays set. A held event input keeps its bit set through a clear.
- R6: Writing to the set port 0x08 sets the mask bits written as one and leaves the other mask bits unchanged.
- R7: Writing to the clear port 0x0C clears the mask bits written as one and leaves the other mask bits unchanged.
- R8: Only bits 6:0 exist. Write data bits 31:7 have no effect, and read data bits 31:7 are always zero.
- R9: The interrupt line is the OR over all bits of status AND mask. It is registered, so it follows a change of status or mask one cycle later.
- R10: Writes to the read-only mask view 0x10, or to an unmapped address, change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 7 | Event inputs, one per status bit |
| irq | output | 1 | Interrupt line |

## Verification
On every cycle, the assertions check how status and mask move from one cycle to the next:
- An event always sets its bit.
- A clear without a coincident event drops the bits it names.
- Bits never fall without a clear.
- The mask moves only under set or clear writes.
- The interrupt line follows status AND mask one cycle later.
- The upper read bits stay zero.

Only the bench scenarios can show that the address decode is correct. They also show that the mask view and unmapped addresses really ignore writes, that write-only ports read as zero, and that a held level source survives an acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_BITS  = 7;
  localparam int BUS_AW    = 8;
  localparam int BUS_DW    = 32;
  localparam logic [BUS_AW-1:0] OFS_STATUS = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_SET    = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_VIEW   = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_SET, SEL_CLEAR, SEL_VIEW
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] evt,
  input  logic [NBITS-1:0] ack,
  output logic [NBITS-1:0] status
);
  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)          bit_q <= 1'b0;
      else if (evt[i])  bit_q <= 1'b1;
      else if (ack[i])  bit_q <= 1'b0;
    end
    assign status[i] = bit_q;
  end

  // R3, R5: an event always leaves its bit set
  a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));
  // R4: an acknowledge without an event drops the bit
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ((ack & ~evt) != '0) |=> ((status & $past(ack & ~evt)) == '0));
  // R3: bits never fall without an acknowledge
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (ack == '0) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set_bits,
  input  logic [NBITS-1:0] clr_bits,
  output logic [NBITS-1:0] mask
);
  logic [NBITS-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | set_bits) & ~clr_bits;
  end
  assign mask = mask_q;

  // R6
  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    ((set_bits & ~clr_bits) != '0) |=> ((mask & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits)));
  // R7
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_bits != '0) |=> ((mask & $past(clr_bits)) == '0));
  // R10: the mask moves only under set or clear
  a_r10_stable: assert property (@(posedge clk) disable iff (rst)
    ((set_bits == '0) && (clr_bits == '0)) |=> $stable(mask));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int NBITS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] status,
  input  logic [NBITS-1:0] mask,
  output logic             irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status & mask);
  end
  assign irq = irq_q;

  // R9
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) != '0) |=> irq);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> !irq);
endmodule

// File: rtl/irq_regs_unit.sv
module irq_regs_unit
  import irq_pkg::*;
#(
  parameter int NBITS = IRQ_BITS,
  parameter int AW    = BUS_AW,
  parameter int DW    = BUS_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NBITS-1:0] evt_in,
  output logic          irq
);
  localparam int PAD = DW - NBITS;

  reg_sel_e         sel;
  logic [NBITS-1:0] wbits;
  logic [NBITS-1:0] ack, set_bits, clr_bits;
  logic [NBITS-1:0] status, mask;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DW-1:NBITS];
  assign wbits = bus_wdata[NBITS-1:0];

  always_comb begin
    case (bus_addr)
      AW'(OFS_STATUS): sel = SEL_STATUS;
      AW'(OFS_SET):    sel = SEL_SET;
      AW'(OFS_CLEAR):  sel = SEL_CLEAR;
      AW'(OFS_VIEW):   sel = SEL_VIEW;
      default:         sel = SEL_NONE;
    endcase
  end

  assign ack      = (bus_we && sel == SEL_STATUS) ? wbits : '0;
  assign set_bits = (bus_we && sel == SEL_SET)    ? wbits : '0;
  assign clr_bits = (bus_we && sel == SEL_CLEAR)  ? wbits : '0;

  irq_status_bank #(.NBITS(NBITS)) u_status (
    .clk(clk), .rst(rst), .evt(evt_in), .ack(ack), .status(status));

  irq_mask_bank #(.NBITS(NBITS)) u_mask (
    .clk(clk), .rst(rst), .set_bits(set_bits), .clr_bits(clr_bits), .mask(mask));

  irq_combine #(.NBITS(NBITS)) u_comb (
    .clk(clk), .rst(rst), .status(status), .mask(mask), .irq(irq));

  always_comb begin
    case (sel)
      SEL_STATUS: rdata_d = {{PAD{1'b0}}, status};
      SEL_VIEW:   rdata_d = {{PAD{1'b0}}, mask};
      default:    rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;

  // R8: unimplemented read bits stay zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:NBITS] == '0);
  // R2: write-only and unmapped reads return zero next cycle
  a_r2_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ((bus_addr != AW'(OFS_STATUS)) && (bus_addr != AW'(OFS_VIEW))) |=> (bus_rdata == '0));
endmodule

// File: tb/irq_regs_unit_test.sv
module irq_regs_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_in = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_regs_unit uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq));

  typedef struct packed {
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wd;
    logic [6:0]  evt;
    logic [6:0]  st;
    logic [6:0]  m;
    logic        irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b0, 32'h0000_0000, 7'h12, 7'h12, 7'h00, 1'b0}, // R3 events
    '{8'h08, 1'b1, 32'h0000_0006, 7'h00, 7'h12, 7'h06, 1'b1}, // R6 set
    '{8'h04, 1'b1, 32'h0000_0002, 7'h00, 7'h10, 7'h06, 1'b0}, // R4 w1c
    '{8'h00, 1'b0, 32'h0000_0000, 7'h0C, 7'h1C, 7'h06, 1'b1}, // R3
    '{8'h0C, 1'b1, 32'h0000_0004, 7'h00, 7'h1C, 7'h02, 1'b0}, // R7 clear
    '{8'h04, 1'b1, 32'hFFFF_FF88, 7'h00, 7'h14, 7'h02, 1'b0}, // R8 upper ignored
    '{8'h08, 1'b1, 32'hFFFF_FF81, 7'h00, 7'h14, 7'h03, 1'b0}, // R6 R8
    '{8'h10, 1'b1, 32'h0000_007F, 7'h00, 7'h14, 7'h03, 1'b0}, // R10 view
    '{8'h20, 1'b1, 32'h0000_007F, 7'h00, 7'h14, 7'h03, 1'b0}, // R10 unmapped
    '{8'h04, 1'b1, 32'h0000_007F, 7'h40, 7'h40, 7'h03, 1'b0}, // R5 event wins
    '{8'h0C, 1'b1, 32'h0000_007F, 7'h00, 7'h40, 7'h00, 1'b0}, // R7
    '{8'h08, 1'b1, 32'h0000_0040, 7'h00, 7'h40, 7'h40, 1'b1}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic [7:0] a, input logic we, input logic [31:0] wd, input logic [6:0] ev);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = wd; evt_in = ev;
    @(negedge clk);
    bus_we = 1'b0; evt_in = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    rd(8'h04, v); check("R1 status", v, 32'h0);
    rd(8'h10, v); check("R1 mask", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      op(VECS[i].addr, VECS[i].we, VECS[i].wd, VECS[i].evt);
      rd(8'h04, v); check($sformatf("R4 vec%0d status", i), v, {25'h0, VECS[i].st});
      rd(8'h10, v); check($sformatf("R6 vec%0d mask", i), v, {25'h0, VECS[i].m});
      check($sformatf("R9 vec%0d irq", i), {31'h0, irq}, {31'h0, VECS[i].irq});
    end

    // R2: write-only ports and unmapped addresses read as zero
    rd(8'h08, v); check("R2 set port read", v, 32'h0);
    rd(8'h0C, v); check("R2 clear port read", v, 32'h0);
    rd(8'h3C, v); check("R2 unmapped read", v, 32'h0);

    // R5: held level source (bit 4, RX not empty) survives acknowledge
    @(negedge clk); evt_in = 7'h10;
    @(negedge clk); bus_addr = 8'h04; bus_we = 1'b1; bus_wdata = 32'h10;
    @(negedge clk); bus_we = 1'b0; bus_wdata = '0;
    @(negedge clk); v = bus_rdata;
    check("R5 held level status", v, 32'h50);
    evt_in = '0;
    op(8'h04, 1'b1, 32'h10, 7'h00);
    rd(8'h04, v); check("R4 level clear after release", v, 32'h40);

    // R9: interrupt drops when mask bit is cleared
    op(8'h0C, 1'b1, 32'h40, 7'h00);
    @(negedge clk);
    check("R9 irq after disable", {31'h0, irq}, 32'h0);

    // R1: reset again clears everything
    op(8'h08, 1'b1, 32'h7F, 7'h7F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(8'h04, v); check("R1 status after reset", v, 32'h0);
    rd(8'h10, v); check("R1 mask after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, irq}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule